// File: doc/BRIEF.md
# Watchdog Timer with Delayed Reset

This block is a watchdog: a counter runs freely from system reset and counts clock edges. Software picks one of four time-out intervals and must restart the counter, with a restart strobe, before the interval runs out. If it does not, the block raises a time-out flag. The flag can serve as an interrupt source and stays set until software clears it.

When reset generation is enabled, the time-out also starts a fixed grace window of 512 clocks. If software neither restarts the counter nor withdraws the enable during that window, the block sends a one-cycle reset request to the system reset controller. The controller stretches that request into the actual reset, which is not part of this block. The same system reset then clears the block.

The block moves no data, so every pin is a plain control or status signal and there is no handshake. Clock prescaling is done outside the block.

Top module: `wdt_delayed_reset`

## Requirements
- R1: While `rst_n` is low, `tmo_flag` and `rst_req` are 0 and the interval counter is cleared. After release, the first time-out comes exactly one full interval later.
- R2: `intv_sel` picks the interval as 2^(BASE_EXP + EXP_STEP*intv_sel) clocks. The defaults 17 and 3 give 2^17, 2^20, 2^23 and 2^26. `tmo_flag` goes high at the interval-th rising edge after the edge that sampled a restart.
- R3: `kick` sampled high clears the counter. A `kick` sampled on the same edge as the expiry suppresses that time-out. Restarts spaced closer than the interval keep `tmo_flag` low indefinitely.
- R4: `tmo_flag` stays high until `flag_clr` is sampled high. A time-out on the same edge as `flag_clr` leaves the flag set.
- R5: With `rst_en` high, `rst_req` is high for exactly one cycle, GRACE (512) edges after the edge that set the flag.
- R6: `rst_req` is never produced if `rst_en` is low at the time-out. `rst_en` sampled low during the grace window cancels the pending request.
- R7: `kick` sampled high during the grace window cancels the pending request.
- R8: A further time-out while a grace window is running does not restart that window. The request stays tied to the first time-out.
- R9: After a time-out the counter starts again from zero, so with no restart time-outs repeat every interval. A cleared flag is set again by the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (already prescaled) |
| rst_n | input | 1 | System reset, active low, asynchronous |
| kick | input | 1 | Restart strobe: clears the counter |
| intv_sel | input | SEL_W | Time-out interval select |
| rst_en | input | 1 | Enables the delayed reset request |
| flag_clr | input | 1 | Clears the time-out flag |
| tmo_flag | output | 1 | Time-out flag |
| rst_req | output | 1 | One-cycle reset request to the reset controller |

## Verification
The flag is due on the L-th rising edge after the edge that samples a restart, where L is the selected interval. The reset request is due GRACE edges after that and falls on the next edge. A flag clear shows one edge after it is sampled. All stimulus changes on the falling edge and outputs are read on the falling edge. The bench therefore counts falling edges from the restart and expects the flag at count L and the request at count L+512. A behavioural model steps on each rising edge with the same sampled inputs and is compared at every falling edge, which covers the mid-window cancellations and repeated expiries cycle by cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Exponent of the interval chosen by a select code.
  function automatic int unsigned intv_exp(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/wdt_interval_counter.sv
module wdt_interval_counter
  import wdt_pkg::*;
#(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BASE_EXP = 17,
  parameter int unsigned EXP_STEP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  localparam int unsigned NSEL  = 1 << SEL_W;
  localparam int unsigned CNT_W = intv_exp(BASE_EXP, EXP_STEP, NSEL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val [NSEL];

  // Last count value of each interval: 2^E - 1.
  for (genvar gi = 0; gi < NSEL; gi++) begin : g_last
    localparam int unsigned E = intv_exp(BASE_EXP, EXP_STEP, gi);
    assign last_val[gi] = CNT_W'({E{1'b1}});
  end

  // Greater-or-equal so that shrinking the interval mid-count still expires.
  assign expire = !kick && (cnt_q >= last_val[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (kick || expire) cnt_q <= '0;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/wdt_tmo_flag.sv
module wdt_tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (expire) flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end
endmodule

// File: rtl/wdt_grace_timer.sv
module wdt_grace_timer #(
  parameter int unsigned GRACE = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic kick,
  input  logic rst_en,
  output logic req
);
  localparam int unsigned GW = (GRACE > 1) ? $clog2(GRACE) : 1;
  localparam logic [GW-1:0] LAST = GW'(GRACE - 1);

  logic          armed_q;
  logic [GW-1:0] gcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gcnt_q  <= '0;
      req     <= 1'b0;
    end else begin
      req <= 1'b0;
      if (armed_q) begin
        if (kick || !rst_en) begin
          armed_q <= 1'b0;
        end else if (gcnt_q == LAST) begin
          req     <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          gcnt_q <= gcnt_q + GW'(1);
        end
      end else if (expire && rst_en) begin
        armed_q <= 1'b1;
        gcnt_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/wdt_delayed_reset.sv
module wdt_delayed_reset #(
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BASE_EXP = 17,
  parameter int unsigned EXP_STEP = 3,
  parameter int unsigned GRACE    = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [SEL_W-1:0] intv_sel,
  input  logic             rst_en,
  input  logic             flag_clr,
  output logic             tmo_flag,
  output logic             rst_req
);
  logic expire;

  wdt_interval_counter #(
    .SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .EXP_STEP(EXP_STEP)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .kick(kick), .sel(intv_sel), .expire(expire)
  );

  wdt_tmo_flag u_flag (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr(flag_clr), .flag(tmo_flag)
  );

  wdt_grace_timer #(.GRACE(GRACE)) u_grace (
    .clk(clk), .rst_n(rst_n), .expire(expire), .kick(kick),
    .rst_en(rst_en), .req(rst_req)
  );
endmodule

// File: rtl/wdt_delayed_reset_chk.sv
module wdt_delayed_reset_chk (
  input logic clk,
  input logic rst_n,
  input logic kick,
  input logic rst_en,
  input logic flag_clr,
  input logic tmo_flag,
  input logic rst_req
);
  // R5: the request is a single-cycle pulse
  assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R6: no request unless enable was sampled high on the issuing edge
  assert_req_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(rst_en));

  // R7: a restart on the issuing edge cancels the request
  assert_req_not_after_kick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(!kick));

  // R3: a restart sampled on an edge prevents a flag rise there
  assert_no_flag_after_kick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(!kick));

  // R4: the flag holds unless a clear is sampled
  assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !flag_clr) |=> tmo_flag);

  // R1: outputs are low while reset is asserted
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!rst_req) else $error("R1 request during reset");
    end
  end
endmodule

bind wdt_delayed_reset wdt_delayed_reset_chk u_chk (
  .clk(clk), .rst_n(rst_n), .kick(kick), .rst_en(rst_en),
  .flag_clr(flag_clr), .tmo_flag(tmo_flag), .rst_req(rst_req)
);

// File: tb/wdt_delayed_reset_tb.sv
`timescale 1ns/1ps
module wdt_delayed_reset_tb;
  localparam int SEL_W = 2;
  localparam int BASE  = 6;
  localparam int STEP  = 2;
  localparam int GRACE = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0;
  logic [SEL_W-1:0] intv_sel = '0;
  logic rst_en = 1'b0;
  logic flag_clr = 1'b0;
  logic tmo_flag, rst_req;

  int checks = 0;
  int fails = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_delayed_reset #(.SEL_W(SEL_W), .BASE_EXP(BASE), .EXP_STEP(STEP), .GRACE(GRACE)) u_dut (
    .clk(clk), .rst_n(rst_n), .kick(kick), .intv_sel(intv_sel), .rst_en(rst_en),
    .flag_clr(flag_clr), .tmo_flag(tmo_flag), .rst_req(rst_req)
  );

  // Behavioural reference, stepped on every rising edge.
  int m_cnt, m_g;
  bit m_flag, m_armed, m_req;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_g = 0; m_flag = 0; m_armed = 0; m_req = 0;
    end else begin
      int lim;
      bit ex, was_armed;
      lim = 1 << (BASE + STEP * int'(intv_sel));
      ex = (m_cnt >= lim - 1) && !kick;
      was_armed = m_armed;
      m_req = 0;
      if (was_armed) begin
        if (kick || !rst_en) m_armed = 0;
        else if (m_g == GRACE - 1) begin m_req = 1; m_armed = 0; end
        else m_g = m_g + 1;
      end else if (ex && rst_en) begin
        m_armed = 1; m_g = 0;
      end
      if (kick || ex) m_cnt = 0; else m_cnt = m_cnt + 1;
      if (ex) m_flag = 1; else if (flag_clr) m_flag = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk(tmo_flag == m_flag, "R2/R3/R4/R9 flag vs model", int'(tmo_flag), int'(m_flag));
      chk(rst_req == m_req, "R5/R6/R7/R8 request vs model", int'(rst_req), int'(m_req));
    end
  end

  task automatic sys_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  // Restart plus flag clear; returns at falling edge index 0 after the sampling edge.
  task automatic kick_clr();
    @(negedge clk); kick = 1'b1; flag_clr = 1'b1;
    @(negedge clk); kick = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic wait_flag(inout int n);
    while (!tmo_flag && n < 10000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_req(inout int n);
    while (!rst_req && n < 10000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(tmo_flag == 1'b0, "R1 flag in reset", int'(tmo_flag), 0);
    chk(rst_req == 1'b0, "R1 request in reset", int'(rst_req), 0);
    rst_n = 1'b1;
    run_cmp = 1'b1;

    // R2: each interval, and R4 hold on the longest one
    for (int s = 0; s < 4; s++) begin
      intv_sel = SEL_W'(s);
      kick_clr();
      chk(tmo_flag == 1'b0, "R3 flag low right after restart", int'(tmo_flag), 0);
      n = 0; wait_flag(n);
      chk(n == (1 << (BASE + STEP * s)), "R2 interval length", n, 1 << (BASE + STEP * s));
    end
    repeat (100) @(negedge clk);
    chk(tmo_flag == 1'b1, "R4 flag held without clear", int'(tmo_flag), 1);

    // R9: repeated expiry, and R4 clear
    intv_sel = '0;
    kick_clr();
    n = 0; wait_flag(n);
    chk(n == 64, "R9 first expiry", n, 64);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; n++;
    chk(tmo_flag == 1'b0, "R4 flag cleared", int'(tmo_flag), 0);
    wait_flag(n);
    chk(n == 128, "R9 next expiry one interval later", n, 128);

    // R3: periodic restarts keep the flag low
    kick_clr();
    for (int i = 0; i < 20; i++) begin
      repeat (40) @(negedge clk);
      kick = 1'b1; @(negedge clk); kick = 1'b0;
    end
    chk(tmo_flag == 1'b0, "R3 periodic restart", int'(tmo_flag), 0);

    // R3: restart on the expiry edge suppresses it; one edge later is too late
    kick_clr();
    repeat (63) @(negedge clk);
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    chk(tmo_flag == 1'b0, "R3 restart on expiry edge", int'(tmo_flag), 0);
    n = 0; wait_flag(n);
    chk(n == 64, "R3 count restarted by boundary kick", n, 64);
    kick_clr();
    repeat (64) @(negedge clk);
    chk(tmo_flag == 1'b1, "R3 restart one edge late", int'(tmo_flag), 1);

    // R5 and R8: delayed request with repeated expiries
    sys_reset();
    rst_en = 1'b1;
    kick_clr();
    n = 0; wait_req(n);
    chk(n == 64 + GRACE, "R5 request delay after flag", n, 64 + GRACE);
    @(negedge clk); n++;
    chk(rst_req == 1'b0, "R5 request one cycle wide", int'(rst_req), 0);
    wait_req(n);
    chk(n == 640 + GRACE, "R8 grace not restarted by later expiries", n, 640 + GRACE);

    // R1: system reset clears counter
    rst_en = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(tmo_flag == 1'b0, "R1 flag cleared by reset", int'(tmo_flag), 0);
    rst_n = 1'b1;
    n = 0; wait_flag(n);
    chk(n == 64, "R1 first expiry after release", n, 64);

    // R6: disabled reset never requests; dropping enable cancels
    kick_clr();
    n = 0;
    for (int i = 0; i < 1200; i++) begin @(negedge clk); if (rst_req) n++; end
    chk(n == 0, "R6 no request while disabled", n, 0);
    sys_reset();
    rst_en = 1'b1;
    kick_clr();
    repeat (300) @(negedge clk);
    rst_en = 1'b0; @(negedge clk); rst_en = 1'b1;
    n = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (rst_req) n++; end
    chk(n == 0, "R6 enable drop cancels pending request", n, 0);

    // R7: restart during grace cancels
    sys_reset();
    intv_sel = 2'd1;
    kick_clr();
    repeat (300) @(negedge clk);
    chk(tmo_flag == 1'b1, "R7 flag set before grace restart", int'(tmo_flag), 1);
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    n = 0;
    for (int i = 0; i < 600; i++) begin @(negedge clk); if (rst_req) n++; end
    chk(n == 0, "R7 restart cancels pending request", n, 0);

    run_cmp = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule